// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the finite-state controller for a 32-bit processor that runs each instruction over several clock cycles. All of those cycles share one ALU and one memory port. The controller receives the 6-bit primary opcode held in the instruction register. In every cycle it raises the strobes and select codes that steer the surrounding datapath: memory address source, memory read and write, instruction register load, register-file write, ALU operand selects and mode, and the next-PC source with its unconditional and conditional load enables.

Every instruction starts with the same two steps. The first is a fetch that loads the instruction and advances PC by four. The second is a decode step that reads both source registers and, using the otherwise idle ALU, precomputes a branch target. After decode, loads take three more steps, stores and register-to-register operations take two, and branches and jumps take one. Equal-branch and not-equal-branch use the same datapath controls. The not-equal case also raises an invert line, so the datapath takes the branch when the ALU Zero flag is clear.

The outputs are a pure function of the current state. The datapath, the memory and the ALU function decoder are separate blocks. The current state code is brought out so that the datapath and the bench can follow the sequence.

Top module: `mcControl`

## Requirements
- R1: A synchronous reset, sampled on a rising clock edge, puts the sequencer in the fetch state, state code 0. The reset has priority over any sequence in progress.
- R2: In fetch (code 0) the outputs are: memRdEn=1, instLoad=1, pcLoad=1, memAddrSel=0 (PC), aluASel=0 (PC), aluBSel=01 (constant 4), aluMode=00 (add) and pcSel=00 (live ALU result). All other strobes are 0. Fetch is always followed by decode (code 1).
- R3: In decode (code 1) the outputs are aluASel=0 and aluBSel=11 (offset shifted left by 2), with aluMode=00. No write strobe is raised: memWrEn, regWrEn, pcLoad, pcLoadCond and instLoad are all 0.
- R4: A load (opcode 100011) passes through codes 0,1,2,3,4. Code 2 has aluASel=1, aluBSel=10 and aluMode=00. Code 3 has memRdEn=1 and memAddrSel=1. Code 4 has regWrEn=1, dstSel=0 (rt) and wbSel=1 (memory data).
- R5: A store (opcode 101011) passes through codes 0,1,2,5. Code 5 has memWrEn=1 and memAddrSel=1.
- R6: A register-to-register operation (opcode 000000) passes through codes 0,1,6,7. Code 6 has aluASel=1, aluBSel=00 and aluMode=10 (function field). Code 7 has regWrEn=1, dstSel=1 (rd) and wbSel=0 (ALU output).
- R7: An equal-branch (opcode 000100) passes through codes 0,1,8. Code 8 has aluASel=1, aluBSel=00, aluMode=01 (subtract), pcSel=01 (ALU output register), pcLoadCond=1, pcLoad=0 and brInvert=0.
- R8: A not-equal-branch (opcode 000101) passes through codes 0,1,10. Code 10 has the same outputs as code 8 except that brInvert=1.
- R9: A jump (opcode 000010) passes through codes 0,1,9. Code 9 has pcSel=10 (jump target) and pcLoad=1. Every final state of a sequence (codes 4,5,7,8,9,10) returns to fetch.
- R10: Any other opcode passes through codes 0,1 and then back to 0. Its decode cycle raises no write strobe.
- R11: memRdEn and memWrEn are never both 1. pcLoad and pcLoadCond are never both 1. brInvert is 1 only together with pcLoadCond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instOp | input | 6 | Primary opcode field from the instruction register |
| memAddrSel | output | 1 | Memory address source: 0 PC, 1 ALU output register |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| instLoad | output | 1 | Instruction register load |
| dstSel | output | 1 | Destination register field: 0 rt, 1 rd |
| wbSel | output | 1 | Write-back data: 0 ALU output register, 1 memory data register |
| regWrEn | output | 1 | Register file write strobe |
| aluASel | output | 1 | ALU operand A: 0 PC, 1 register A |
| aluBSel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 sign-extended offset, 11 offset shifted left 2 |
| aluMode | output | 2 | ALU mode: 00 add, 01 subtract, 10 use function field |
| pcSel | output | 2 | Next PC source: 00 live ALU result, 01 ALU output register, 10 jump target |
| pcLoad | output | 1 | Unconditional PC load |
| pcLoadCond | output | 1 | PC load gated by the branch condition |
| brInvert | output | 1 | Take the branch on Zero clear rather than Zero set |
| curState | output | 4 | Current state code |

## Verification
The assertions assume that instOp holds steady from the decode cycle to the end of each instruction, since the instruction register only loads during fetch. The sequence checks that look past decode rely on this. The stimulus sets the opcode only in the fetch cycle, or while reset is held, and keeps it unchanged until the sequencer is back in fetch. It also exercises a reset raised in the middle of a load, which is the one point where a sequence may stop early.

// File: rtl/mcCtrlPkg.sv
package mcCtrlPkg;

  typedef enum logic [3:0] {
    S_FETCH   = 4'd0,
    S_DECODE  = 4'd1,
    S_MEMADDR = 4'd2,
    S_MEMRD   = 4'd3,
    S_LDWB    = 4'd4,
    S_MEMWR   = 4'd5,
    S_EXEC    = 4'd6,
    S_RWB     = 4'd7,
    S_BEQ     = 4'd8,
    S_JUMP    = 4'd9,
    S_BNE     = 4'd10
  } ctrlState_e;

  localparam int STATE_W = $bits(ctrlState_e);

  // Operand B, ALU mode and next-PC select codes
  localparam logic [1:0] B_REG   = 2'b00;
  localparam logic [1:0] B_FOUR  = 2'b01;
  localparam logic [1:0] B_SEXT  = 2'b10;
  localparam logic [1:0] B_SHIFT = 2'b11;

  localparam logic [1:0] M_ADD   = 2'b00;
  localparam logic [1:0] M_SUB   = 2'b01;
  localparam logic [1:0] M_FUNCT = 2'b10;

  localparam logic [1:0] PC_LIVE = 2'b00;
  localparam logic [1:0] PC_HELD = 2'b01;
  localparam logic [1:0] PC_JUMP = 2'b10;

  typedef struct packed {
    logic       memAddrSel;
    logic       memRdEn;
    logic       memWrEn;
    logic       instLoad;
    logic       dstSel;
    logic       wbSel;
    logic       regWrEn;
    logic       aluASel;
    logic [1:0] aluBSel;
    logic [1:0] aluMode;
    logic [1:0] pcSel;
    logic       pcLoad;
    logic       pcLoadCond;
    logic       brInvert;
  } ctrlStrobes_t;

endpackage

// File: rtl/mcSeq.sv
module mcSeq
  import mcCtrlPkg::*;
#(
  parameter int                OP_W   = 6,
  parameter logic [OP_W-1:0]   OP_RTY = 6'b000000,
  parameter logic [OP_W-1:0]   OP_LD  = 6'b100011,
  parameter logic [OP_W-1:0]   OP_ST  = 6'b101011,
  parameter logic [OP_W-1:0]   OP_BEQ = 6'b000100,
  parameter logic [OP_W-1:0]   OP_BNE = 6'b000101,
  parameter logic [OP_W-1:0]   OP_JMP = 6'b000010
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] instOp,
  output ctrlState_e      state
);

  ctrlState_e nextState;
  logic isLoad, isStore, isRty, isBeq, isBne, isJmp, isKnown;

  assign isLoad  = (instOp == OP_LD);
  assign isStore = (instOp == OP_ST);
  assign isRty   = (instOp == OP_RTY);
  assign isBeq   = (instOp == OP_BEQ);
  assign isBne   = (instOp == OP_BNE);
  assign isJmp   = (instOp == OP_JMP);
  assign isKnown = isLoad | isStore | isRty | isBeq | isBne | isJmp;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nextState;
  end

  always_comb begin
    nextState = S_FETCH;
    case (state)
      S_FETCH:  nextState = S_DECODE;
      S_DECODE: begin
        if (isLoad || isStore) nextState = S_MEMADDR;
        else if (isRty)        nextState = S_EXEC;
        else if (isBeq)        nextState = S_BEQ;
        else if (isBne)        nextState = S_BNE;
        else if (isJmp)        nextState = S_JUMP;
        else                   nextState = S_FETCH;
      end
      S_MEMADDR: begin
        if (isLoad)       nextState = S_MEMRD;
        else if (isStore) nextState = S_MEMWR;
        else              nextState = S_FETCH;
      end
      S_MEMRD:  nextState = S_LDWB;
      S_EXEC:   nextState = S_RWB;
      default:  nextState = S_FETCH;
    endcase
  end

  // Sequence checks
  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> state == S_DECODE);

  p_memrd_after_addr_r4: assert property (@(posedge clk) disable iff (rst)
    state == S_MEMRD |-> $past(state) == S_MEMADDR);

  p_memwr_after_addr_r5: assert property (@(posedge clk) disable iff (rst)
    state == S_MEMWR |-> $past(state) == S_MEMADDR);

  p_exec_after_decode_r6: assert property (@(posedge clk) disable iff (rst)
    state == S_EXEC |-> $past(state) == S_DECODE);

  p_last_to_fetch_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_LDWB || state == S_MEMWR || state == S_RWB ||
     state == S_BEQ || state == S_BNE || state == S_JUMP) |=> state == S_FETCH);

  p_unknown_to_fetch_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE && !isKnown) |=> state == S_FETCH);

endmodule

// File: rtl/mcDecode.sv
module mcDecode
  import mcCtrlPkg::*;
(
  input  ctrlState_e   state,
  output ctrlStrobes_t strb
);

  always_comb begin
    strb = '0;
    case (state)
      S_FETCH: begin
        strb.memRdEn  = 1'b1;
        strb.instLoad = 1'b1;
        strb.aluBSel  = B_FOUR;
        strb.aluMode  = M_ADD;
        strb.pcSel    = PC_LIVE;
        strb.pcLoad   = 1'b1;
      end
      S_DECODE: begin
        strb.aluBSel = B_SHIFT;
        strb.aluMode = M_ADD;
      end
      S_MEMADDR: begin
        strb.aluASel = 1'b1;
        strb.aluBSel = B_SEXT;
        strb.aluMode = M_ADD;
      end
      S_MEMRD: begin
        strb.memRdEn    = 1'b1;
        strb.memAddrSel = 1'b1;
      end
      S_LDWB: begin
        strb.regWrEn = 1'b1;
        strb.wbSel   = 1'b1;
      end
      S_MEMWR: begin
        strb.memWrEn    = 1'b1;
        strb.memAddrSel = 1'b1;
      end
      S_EXEC: begin
        strb.aluASel = 1'b1;
        strb.aluBSel = B_REG;
        strb.aluMode = M_FUNCT;
      end
      S_RWB: begin
        strb.regWrEn = 1'b1;
        strb.dstSel  = 1'b1;
      end
      S_BEQ, S_BNE: begin
        strb.aluASel    = 1'b1;
        strb.aluBSel    = B_REG;
        strb.aluMode    = M_SUB;
        strb.pcSel      = PC_HELD;
        strb.pcLoadCond = 1'b1;
        strb.brInvert   = (state == S_BNE);
      end
      S_JUMP: begin
        strb.pcSel  = PC_JUMP;
        strb.pcLoad = 1'b1;
      end
      default: strb = '0;
    endcase
  end

endmodule

// File: rtl/mcControl.sv
module mcControl
  import mcCtrlPkg::*;
#(
  parameter int              OP_W   = 6,
  parameter logic [OP_W-1:0] OP_RTY = 6'b000000,
  parameter logic [OP_W-1:0] OP_LD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_ST  = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ = 6'b000100,
  parameter logic [OP_W-1:0] OP_BNE = 6'b000101,
  parameter logic [OP_W-1:0] OP_JMP = 6'b000010
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] instOp,
  output logic            memAddrSel,
  output logic            memRdEn,
  output logic            memWrEn,
  output logic            instLoad,
  output logic            dstSel,
  output logic            wbSel,
  output logic            regWrEn,
  output logic            aluASel,
  output logic [1:0]      aluBSel,
  output logic [1:0]      aluMode,
  output logic [1:0]      pcSel,
  output logic            pcLoad,
  output logic            pcLoadCond,
  output logic            brInvert,
  output logic [3:0]      curState
);

  ctrlState_e   state;
  ctrlStrobes_t strb;

  mcSeq #(
    .OP_W(OP_W), .OP_RTY(OP_RTY), .OP_LD(OP_LD), .OP_ST(OP_ST),
    .OP_BEQ(OP_BEQ), .OP_BNE(OP_BNE), .OP_JMP(OP_JMP)
  ) uSeq (
    .clk    (clk),
    .rst    (rst),
    .instOp (instOp),
    .state  (state)
  );

  mcDecode uDec (
    .state (state),
    .strb  (strb)
  );

  assign memAddrSel = strb.memAddrSel;
  assign memRdEn    = strb.memRdEn;
  assign memWrEn    = strb.memWrEn;
  assign instLoad   = strb.instLoad;
  assign dstSel     = strb.dstSel;
  assign wbSel      = strb.wbSel;
  assign regWrEn    = strb.regWrEn;
  assign aluASel    = strb.aluASel;
  assign aluBSel    = strb.aluBSel;
  assign aluMode    = strb.aluMode;
  assign pcSel      = strb.pcSel;
  assign pcLoad     = strb.pcLoad;
  assign pcLoadCond = strb.pcLoadCond;
  assign brInvert   = strb.brInvert;
  assign curState   = state;

  // Strobe checks
  p_fetch_loads_r2: assert property (@(posedge clk) disable iff (rst)
    curState == 4'd0 |-> (instLoad && pcLoad && memRdEn && !memWrEn));

  p_decode_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    curState == 4'd1 |-> !(memWrEn || regWrEn || pcLoad || pcLoadCond || instLoad));

  p_cond_not_taken_early_r7: assert property (@(posedge clk) disable iff (rst)
    pcLoadCond |-> $past(curState) == 4'd1);

  p_invert_only_bne_r8: assert property (@(posedge clk) disable iff (rst)
    brInvert |-> curState == 4'd10);

  p_mem_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(memRdEn && memWrEn));

  p_pc_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(pcLoad && pcLoadCond));

  p_invert_with_cond_r11: assert property (@(posedge clk) disable iff (rst)
    brInvert |-> pcLoadCond);

endmodule

// File: tb/tb_mcControl.sv
module tb_mcControl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] instOp = 6'b000000;
  logic       memAddrSel, memRdEn, memWrEn, instLoad, dstSel, wbSel, regWrEn;
  logic       aluASel, pcLoad, pcLoadCond, brInvert;
  logic [1:0] aluBSel, aluMode, pcSel;
  logic [3:0] curState;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mcControl dut (
    .clk(clk), .rst(rst), .instOp(instOp),
    .memAddrSel(memAddrSel), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .instLoad(instLoad), .dstSel(dstSel), .wbSel(wbSel), .regWrEn(regWrEn),
    .aluASel(aluASel), .aluBSel(aluBSel), .aluMode(aluMode), .pcSel(pcSel),
    .pcLoad(pcLoad), .pcLoadCond(pcLoadCond), .brInvert(brInvert),
    .curState(curState)
  );

  // Vector: {opcode[6], length[3], five 4-bit state codes, first one highest}
  localparam int NV = 10;
  localparam logic [28:0] VEC [NV] = '{
    {6'b100011, 3'd5, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4},  // R4 load
    {6'b101011, 3'd4, 4'd0, 4'd1, 4'd2, 4'd5, 4'd0},  // R5 store
    {6'b000000, 3'd4, 4'd0, 4'd1, 4'd6, 4'd7, 4'd0},  // R6 reg-reg
    {6'b000100, 3'd3, 4'd0, 4'd1, 4'd8, 4'd0, 4'd0},  // R7 beq
    {6'b000101, 3'd3, 4'd0, 4'd1, 4'd10, 4'd0, 4'd0}, // R8 bne
    {6'b000010, 3'd3, 4'd0, 4'd1, 4'd9, 4'd0, 4'd0},  // R9 jump
    {6'b111111, 3'd2, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0},  // R10 unknown
    {6'b000001, 3'd2, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0},  // R10 unknown
    {6'b000101, 3'd3, 4'd0, 4'd1, 4'd10, 4'd0, 4'd0}, // R8 again
    {6'b100011, 3'd5, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4}   // R4 back to back
  };

  // Expected outputs per state, in order:
  // memAddrSel memRdEn memWrEn instLoad dstSel wbSel regWrEn aluASel
  // aluBSel[2] aluMode[2] pcSel[2] pcLoad pcLoadCond brInvert
  function automatic logic [17:0] expOut(input logic [3:0] s);
    case (s)
      4'd0:  return 18'b0_1_0_1_0_0_0_0_01_00_00_1_0_0;
      4'd1:  return 18'b0_0_0_0_0_0_0_0_11_00_00_0_0_0;
      4'd2:  return 18'b0_0_0_0_0_0_0_1_10_00_00_0_0_0;
      4'd3:  return 18'b1_1_0_0_0_0_0_0_00_00_00_0_0_0;
      4'd4:  return 18'b0_0_0_0_0_1_1_0_00_00_00_0_0_0;
      4'd5:  return 18'b1_0_1_0_0_0_0_0_00_00_00_0_0_0;
      4'd6:  return 18'b0_0_0_0_0_0_0_1_00_10_00_0_0_0;
      4'd7:  return 18'b0_0_0_0_1_0_1_0_00_00_00_0_0_0;
      4'd8:  return 18'b0_0_0_0_0_0_0_1_00_01_01_0_1_0;
      4'd9:  return 18'b0_0_0_0_0_0_0_0_00_00_10_1_0_0;
      4'd10: return 18'b0_0_0_0_0_0_0_1_00_01_01_0_1_1;
      default: return 18'b0;
    endcase
  endfunction

  function automatic string tagFor(input logic [3:0] s);
    case (s)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8: return "R7";
      4'd10: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [17:0] actOut();
    return {memAddrSel, memRdEn, memWrEn, instLoad, dstSel, wbSel, regWrEn,
            aluASel, aluBSel, aluMode, pcSel, pcLoad, pcLoadCond, brInvert};
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic checkCycle(input string tag, input logic [3:0] expState);
    check({tag, " state"}, {14'd0, curState}, {14'd0, expState});
    check({tag, " strobes"}, actOut(), expOut(expState));
    // R11 exclusivity
    check("R11 excl", {15'd0, memRdEn & memWrEn, pcLoad & pcLoadCond, brInvert & ~pcLoadCond}, 18'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checkCycle("R1", 4'd0);
    rst = 1'b0;

    // Vector table walk; opcode set during fetch, held until back in fetch
    for (int v = 0; v < NV; v++) begin
      logic [28:0] e;
      int len;
      e = VEC[v];
      instOp = e[28:23];
      len = int'(e[22:20]);
      for (int i = 0; i < len; i++) begin
        logic [3:0] s;
        s = e[19 - 4*i -: 4];
        checkCycle(tagFor(s), s);
        @(negedge clk);
      end
      // R9 / R10: every sequence returns to fetch
      check((len == 2) ? "R10 return" : "R9 return", {14'd0, curState}, 18'd0);
    end

    // R1: reset in the middle of a load
    instOp = 6'b100011;
    checkCycle("R4", 4'd0);
    @(negedge clk);
    checkCycle("R4", 4'd1);
    @(negedge clk);
    checkCycle("R4", 4'd2);
    rst = 1'b1;
    @(negedge clk);
    checkCycle("R1", 4'd0);
    @(negedge clk);
    checkCycle("R1", 4'd0);
    rst = 1'b0;

    // R10: unknown opcode decode raises no write strobe, then fetch
    instOp = 6'b010101;
    checkCycle("R2", 4'd0);
    @(negedge clk);
    check("R10 quiet", {13'd0, memWrEn, regWrEn, pcLoad, pcLoadCond, instLoad}, 18'd0);
    @(negedge clk);
    checkCycle("R10", 4'd0);

    // R7 then R6 to close
    instOp = 6'b000100;
    for (int i = 0; i < 3; i++) begin
      checkCycle("R7", (i == 0) ? 4'd0 : (i == 1) ? 4'd1 : 4'd8);
      @(negedge clk);
    end
    instOp = 6'b000000;
    for (int i = 0; i < 4; i++) begin
      checkCycle("R6", (i == 0) ? 4'd0 : (i == 1) ? 4'd1 : (i == 2) ? 4'd6 : 4'd7);
      @(negedge clk);
    end
    checkCycle("R9", 4'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule